// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator

This block is the digital heart of a frequency-locked loop that pulls a tapped oscillator onto a chosen multiple of a slow reference. Two single-cycle tick inputs arrive in the system clock domain. The first marks each period of the reference. The second marks each cycle of the oscillator. The oscillator ticks pass through a two-stage prescaler. The first stage divides by 1, 2, 4 or 8. The second stage divides by a 7-bit multiplier plus one. Each prescaler wrap lowers a 10-bit integrator by one. Each reference tick raises it by one. The loop settles where the two rates match.

The integrator drives the oscillator in two ways. Its upper five bits pick a coarse tap. Its lower five bits set a fractional weight. A modulator uses that weight to blend the chosen tap with the next one up, once for every 32 oscillator ticks. The integrator value is also available on an output for status reads. The oscillator is not part of this block. The testbench models it as a stream of ticks.

Top module: `fll_integrator`

## Requirements
- R1: While reset is asserted, the integrator is loaded to 512, the tap output reads 16, the next-tap select is low, and both prescaler counters and the modulator accumulator are cleared.
- R2: A reference tick raises the integrator by exactly one. The new value appears on `integ_value` in the cycle after the edge that samples the tick.
- R3: The integrator drops by one on every D*(N+1)-th oscillator tick, where N is `mult_n` and D is chosen by `div_sel`: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. The ticks before that one leave the integrator unchanged.
- R4: If a reference tick and a prescaler wrap land in the same cycle, they cancel and the integrator does not change.
- R5: The integrator saturates. At 1023 a further up event leaves it at 1023. At 0 a further down event leaves it at 0.
- R6: `tap_index` equals integrator bits [9:5] when those bits are 27 or less. Any value from 28 to 31 gives 28, the top tap.
- R7: With integrator bits [4:0] equal to M, exactly M of any 32 consecutive oscillator ticks see `tap_next` high. When M is 16 or less, two consecutive oscillator ticks never both see it high.
- R8: While `mod_off` is high, `tap_next` stays low.
- R9: While `tap_index` is 28, `tap_next` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| mult_n | input | 7 | Multiplier N; the second prescaler stage divides by N+1 |
| div_sel | input | 2 | First prescaler stage: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| mod_off | input | 1 | High forces the base tap on every cycle |
| integ_value | output | 10 | Current integrator value |
| tap_index | output | 5 | Coarse tap index, 0 to 28 |
| tap_next | output | 1 | High when the oscillator should use the tap above `tap_index` in this cycle |

## Verification
The bench counts the exact tick on which each prescaler setting produces its decrement. A divider with an off-by-one limit would move the integrator one tick too early or too late. It drives the integrator past both rails. A wrapping design would jump to the opposite end. It fires up and down events in the same cycle. A design that lets one side win would drift. It counts next-tap cycles over a full 32-tick window for several weights, including 0-like, half and near-full values. A bunched or miscounted modulator would fail on adjacency or on the total. It also checks the top-tap clamp and the disable control. In both cases a design without the override would still blend taps.

// File: rtl/fll_integrator.sv
module fll_integrator #(
  parameter int INT_W   = 10,
  parameter int TAP_W   = 5,
  parameter int N_W     = 7,
  parameter int MAX_TAP = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             osc_tick,
  input  logic [N_W-1:0]   mult_n,
  input  logic [1:0]       div_sel,
  input  logic             mod_off,
  output logic [INT_W-1:0] integ_value,
  output logic [TAP_W-1:0] tap_index,
  output logic             tap_next
);
  localparam int MOD_W = INT_W - TAP_W;
  localparam logic [INT_W-1:0] INT_MAX = {INT_W{1'b1}};
  localparam logic [INT_W-1:0] INT_MID = INT_W'(1) << (INT_W - 1);
  localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(MAX_TAP);

  logic [2:0]       dcnt, dlim;
  logic [N_W-1:0]   ncnt;
  logic [MOD_W-1:0] acc;
  logic             d_wrap, n_wrap, down_evt;

  always_comb
    case (div_sel)
      2'd0:    dlim = 3'd0;
      2'd1:    dlim = 3'd1;
      2'd2:    dlim = 3'd3;
      default: dlim = 3'd7;
    endcase

  assign d_wrap   = dcnt >= dlim;
  assign n_wrap   = ncnt >= mult_n;
  assign down_evt = osc_tick && d_wrap && n_wrap;

  always_ff @(posedge clk)
    if (!rst_n) begin
      dcnt <= '0;
      ncnt <= '0;
    end else if (osc_tick) begin
      dcnt <= d_wrap ? 3'd0 : dcnt + 3'd1;
      if (d_wrap) ncnt <= n_wrap ? '0 : ncnt + 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n)
      integ_value <= INT_MID;
    else if (ref_tick && !down_evt && integ_value != INT_MAX)
      integ_value <= integ_value + 1'b1;
    else if (down_evt && !ref_tick && integ_value != '0)
      integ_value <= integ_value - 1'b1;

  logic [TAP_W-1:0] coarse;
  logic [MOD_W-1:0] mval;
  logic [MOD_W:0]   acc_sum;

  assign coarse    = integ_value[INT_W-1 -: TAP_W];
  assign mval      = integ_value[MOD_W-1:0];
  assign tap_index = (coarse > TAP_TOP) ? TAP_TOP : coarse;
  assign acc_sum   = {1'b0, acc} + {1'b0, mval};
  assign tap_next  = acc_sum[MOD_W] && !mod_off && (tap_index != TAP_TOP);

  always_ff @(posedge clk)
    if (!rst_n)        acc <= '0;
    else if (osc_tick) acc <= acc_sum[MOD_W-1:0];

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_value == $past(integ_value)) ||
    (integ_value == $past(integ_value) + 1'b1) ||
    (integ_value == $past(integ_value) - 1'b1));

  assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && down_evt) |=> $stable(integ_value));

  assert_sat_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_value == INT_MAX && !down_evt) |=> integ_value == INT_MAX);

  assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_value == '0 && !ref_tick) |=> integ_value == '0);

  assert_tap_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tap_index <= TAP_TOP);

  assert_mod_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_off |-> !tap_next);

  assert_top_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_index == TAP_TOP) |-> !tap_next);
endmodule

// File: tb/fll_integrator_test.sv
module fll_integrator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, osc_tick = 1'b0, mod_off = 1'b0;
  logic [6:0] mult_n = 7'd0;
  logic [1:0] div_sel = 2'd0;
  logic [9:0] integ_value;
  logic [4:0] tap_index;
  logic       tap_next;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fll_integrator uut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .mult_n(mult_n), .div_sel(div_sel), .mod_off(mod_off),
    .integ_value(integ_value), .tap_index(tap_index), .tap_next(tap_next));

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit r, bit o);
    @(negedge clk); ref_tick = r; osc_tick = o;
    @(negedge clk); ref_tick = 0; osc_tick = 0;
  endtask

  task automatic set_value(int target);
    mult_n = 0; div_sel = 0;
    while (int'(integ_value) != target)
      if (int'(integ_value) < target) pulse(1, 0); else pulse(0, 1);
  endtask

  task automatic test_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 integ", integ_value, 512);
    check("R1 tap", tap_index, 16);
    check("R1 next", tap_next, 0);
    rst_n = 1;
  endtask

  task automatic test_up;
    repeat (3) pulse(1, 0);
    check("R2 up", integ_value, 515);
  endtask

  task automatic test_cancel;
    mult_n = 0; div_sel = 0;
    pulse(1, 1);
    check("R4 cancel", integ_value, 515);
  endtask

  task automatic test_prescale(int n, int dsel);
    int base, total;
    mult_n = 7'(n); div_sel = 2'(dsel);
    total = (1 << dsel) * (n + 1);
    base = integ_value;
    for (int i = 1; i < total; i++) pulse(0, 1);
    check("R3 before wrap", integ_value, base);
    pulse(0, 1);
    check("R3 at wrap", integ_value, base - 1);
  endtask

  task automatic test_tap(int v, int exp);
    set_value(v);
    check("R6 tap", tap_index, exp);
  endtask

  task automatic test_sat;
    set_value(1023);
    repeat (4) pulse(1, 0);
    check("R5 high rail", integ_value, 1023);
    set_value(0);
    repeat (4) pulse(0, 1);
    check("R5 low rail", integ_value, 0);
  endtask

  task automatic count_window(string req, int v, int exp, bit adj);
    int cnt = 0, pairs = 0;
    bit prev = 0;
    set_value(v);
    mult_n = 7'd127; div_sel = 2'd3;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); osc_tick = 1;
      #1;
      if (tap_next) begin cnt++; if (prev) pairs++; end
      prev = tap_next;
    end
    @(negedge clk); osc_tick = 0;
    check(req, cnt, exp);
    if (adj) check("R7 spread", pairs, 0);
  endtask

  initial begin
    test_reset();
    test_up();
    test_cancel();
    test_prescale(2, 1);
    test_prescale(0, 3);
    test_prescale(4, 2);
    test_tap(895, 27);
    test_tap(906, 28);
    test_tap(1023, 28);
    test_sat();
    count_window("R7 M=5", 16*32 + 5, 5, 1);
    count_window("R7 M=16", 10*32 + 16, 16, 1);
    count_window("R7 M=31", 3*32 + 31, 31, 0);
    mod_off = 1;
    count_window("R8 disabled", 12*32 + 20, 0, 0);
    mod_off = 0;
    count_window("R9 top tap", 28*32 + 10, 0, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule